// File: doc/BRIEF.md
# Synchronous FIFO with programmable level flags

A single-clock first-in first-out buffer for 9-bit words held in an inferred dual-port memory whose depth is a parameter. Writes and reads each need two enables. The second write enable is a dual-role pin. The level it holds while reset is asserted fixes its role until the next reset. In dual-enable mode it is an ordinary active-high second write enable. In load mode, driving it LOW reserves the port for offset access, so no FIFO write or read takes place while it stays LOW.

Four active-low flags report the fill level: empty, full, almost-empty and almost-full. The two "almost" flags compare the stored word count against offset values that are supplied on input ports. Read data is registered. The output register keeps the last word that was validly read. An active-low output enable gates the data port, and a disabled port reads as all zeros.

Top module: `lvl_fifo`

## Requirements
- R1: While `rst_n` is LOW at a clock edge, the block is cleared: `empty_n` is LOW, `full_n` is HIGH, `almost_empty_n` is LOW, and the output register holds zero. Empty and full are never asserted together.
- R2: The value of `wen2_ld` on the last clock edge with `rst_n` LOW selects the mode and holds it until the next reset. HIGH selects dual-enable mode and LOW selects load mode.
- R3: A word is written on a rising edge only when `wen1_n` is LOW, `wen2_ld` is HIGH and `full_n` is HIGH. This holds in both modes.
- R4: In load mode, while `wen2_ld` is LOW, neither writes nor reads change the FIFO. In dual-enable mode, `wen2_ld` has no effect on reads.
- R5: A read happens on a rising edge only when `ren1_n` and `ren2_n` are both LOW and `empty_n` is HIGH. Words leave in write order and appear on `dout` after that edge.
- R6: `full_n` is LOW when the count equals DEPTH, and a write attempted in that state is ignored.
- R7: A read attempted while empty is ignored, and `dout` keeps the last word validly read.
- R8: `almost_empty_n` is LOW exactly when the stored count is less than or equal to `ae_ofs`.
- R9: `almost_full_n` is LOW exactly when DEPTH minus the stored count is less than or equal to `af_ofs`.
- R10: While `oe_n` is HIGH, `dout` is all zeros. The output register is not disturbed, and its value returns when `oe_n` goes LOW.
- R11: When a write and a read both qualify on the same edge, both take effect and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | DW | Write data |
| wen1_n | input | 1 | First write enable, active low |
| wen2_ld | input | 1 | Second write enable or load select; sampled during reset to set the mode |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low; HIGH forces `dout` to zero |
| ae_ofs | input | $clog2(DEPTH)+1 | Almost-empty offset |
| af_ofs | input | $clog2(DEPTH)+1 | Almost-full offset |
| dout | output | DW | Registered read data, gated by `oe_n` |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |

## Verification
The case that is hardest to reach from the ports is a dual-role pin that behaves differently in the two modes. The only way to select a mode is through the pin level during reset, so the stimulus resets the block twice, once with each level. After each reset it drives `wen2_ld` LOW together with both read enables LOW. A read must go through in dual-enable mode and must be held back in load mode. The stimulus also fills the FIFO and then drains it to empty with simultaneous reads and writes, so that the overflow guard, the underflow guard and every threshold crossing of the almost flags are reached.

// File: rtl/lvl_fifo.sv
module lvl_fifo #(
  parameter int DW    = 9,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          oe_n,
  input  logic [PW-1:0] ae_ofs,
  input  logic [PW-1:0] af_ofs,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          full_n,
  output logic          almost_empty_n,
  output logic          almost_full_n
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [DW-1:0] q_r;
  logic          mode_dual;

  logic [PW-1:0] cnt, room;
  logic          port_free, wr_go, rd_go;

  assign cnt  = wptr - rptr;
  assign room = PW'(DEPTH) - cnt;

  assign empty_n        = (cnt != '0);
  assign full_n         = (cnt != PW'(DEPTH));
  assign almost_empty_n = !(cnt <= ae_ofs);
  assign almost_full_n  = !(room <= af_ofs);

  assign port_free = mode_dual || wen2_ld;
  assign wr_go = !wen1_n && wen2_ld && full_n;
  assign rd_go = !ren1_n && !ren2_n && empty_n && port_free;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_dual <= wen2_ld;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      q_r  <= '0;
    end else begin
      if (wr_go) wptr <= wptr + 1'b1;
      if (rd_go) begin
        rptr <= rptr + 1'b1;
        q_r  <= mem[rptr[AW-1:0]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && wr_go) mem[wptr[AW-1:0]] <= din;
  end

  assign dout = oe_n ? '0 : q_r;

endmodule

// File: rtl/lvl_fifo_chk.sv
module lvl_fifo_chk #(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wen1_n,
  input logic          wen2_ld,
  input logic          ren1_n,
  input logic          ren2_n,
  input logic          oe_n,
  input logic [DW-1:0] dout,
  input logic          empty_n,
  input logic          full_n,
  input logic          almost_empty_n,
  input logic [DW-1:0] q_r,
  input logic          mode_dual
);

  // R1
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_n || full_n));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_dual));

  // R4
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_dual && !wen2_ld) |=> ($stable(q_r) && $stable(empty_n) && $stable(full_n)));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && (ren1_n || ren2_n)) |=> !full_n);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && wen1_n) |=> (!empty_n && $stable(q_r)));

  // R8
  ae_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !almost_empty_n);

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (dout == '0));

endmodule

bind lvl_fifo lvl_fifo_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
  .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .dout(dout),
  .empty_n(empty_n), .full_n(full_n), .almost_empty_n(almost_empty_n),
  .q_r(q_r), .mode_dual(mode_dual)
);

// File: tb/sim_lvl_fifo.sv
module sim_lvl_fifo;
  localparam int DW = 9;
  localparam int DEPTH = 16;
  localparam int PW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, wen1_n, wen2_ld, ren1_n, ren2_n, oe_n;
  logic [DW-1:0] din, dout;
  logic [PW-1:0] ae_ofs, af_ofs;
  logic empty_n, full_n, almost_empty_n, almost_full_n;

  lvl_fifo #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .dout(dout), .empty_n(empty_n), .full_n(full_n),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
  );

  int nvec = 0;
  int nbad = 0;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] exp_dout;
  bit mdl_dual;
  bit mon_on = 0;
  string tag = "R1";

  task automatic chk(string req, int act, int expv);
    nvec++;
    if (act != expv) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: pops of the model are compared against the port values
  always @(negedge clk) begin
    if (mon_on) begin
      chk(tag, int'(dout), oe_n ? 0 : int'(exp_dout));
      chk("R6 full_n", int'(full_n), (mq.size() == DEPTH) ? 0 : 1);
      chk("R5 empty_n", int'(empty_n), (mq.size() == 0) ? 0 : 1);
      chk("R8 almost_empty_n", int'(almost_empty_n), (mq.size() <= int'(ae_ofs)) ? 0 : 1);
      chk("R9 almost_full_n", int'(almost_full_n), ((DEPTH - mq.size()) <= int'(af_ofs)) ? 0 : 1);
    end
  end

  // driver: predicts the effect and updates the scoreboard after the edge
  task automatic step(bit w, logic [DW-1:0] d, bit r1, bit r2, bit ld);
    bit wf, rf;
    wen1_n = !w; din = d; ren1_n = !r1; ren2_n = !r2; wen2_ld = ld;
    wf = w && ld && (mq.size() < DEPTH);
    rf = r1 && r2 && (mq.size() > 0) && (mdl_dual || ld);
    @(posedge clk); #1;
    if (rf) exp_dout = mq.pop_front();
    if (wf) mq.push_back(d);
  endtask

  task automatic do_reset(bit ld);
    mon_on = 0;
    rst_n = 0; wen2_ld = ld; wen1_n = 1; ren1_n = 1; ren2_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 dout", int'(dout), 0);
    chk("R1 empty_n", int'(empty_n), 0);
    chk("R1 full_n", int'(full_n), 1);
    chk("R1 almost_empty_n", int'(almost_empty_n), 0);
    @(posedge clk); #1;
    rst_n = 1; wen2_ld = 1;
    mdl_dual = ld; mq.delete(); exp_dout = '0; mon_on = 1;
  endtask

  initial begin
    rst_n = 0; wen1_n = 1; wen2_ld = 1; ren1_n = 1; ren2_n = 1; oe_n = 0;
    din = '0; ae_ofs = PW'(3); af_ofs = PW'(2); exp_dout = '0;
    do_reset(1);

    tag = "R3 fill";
    for (int i = 0; i < DEPTH; i++) step(1, DW'(i * 7 + 1), 0, 0, 1);
    tag = "R6 write when full";
    step(1, 9'h1AA, 0, 0, 1);
    step(1, 9'h155, 0, 0, 1);
    tag = "R4 dual mode ld low read";
    step(1, 9'h0F0, 1, 1, 0);
    tag = "R3 dual mode wen2 low";
    step(1, 9'h0F1, 0, 0, 0);
    tag = "R5 single enable";
    step(0, '0, 1, 0, 1);
    step(0, '0, 0, 1, 1);
    tag = "R5 read order";
    for (int i = 0; i < 5; i++) step(0, '0, 1, 1, 1);
    tag = "R11 simultaneous";
    for (int i = 0; i < 4; i++) step(1, DW'(9'h100 + i), 1, 1, 1);
    tag = "R10 oe gate";
    oe_n = 1;
    step(0, '0, 1, 1, 1);
    step(0, '0, 0, 0, 1);
    oe_n = 0;
    step(0, '0, 0, 0, 1);
    ae_ofs = '0; af_ofs = '0;
    tag = "R5 drain";
    for (int i = 0; i < DEPTH; i++) step(0, '0, 1, 1, 1);
    tag = "R7 read when empty";
    for (int i = 0; i < 3; i++) step(0, '0, 1, 1, 1);
    tag = "R11 empty rd+wr";
    step(1, 9'h0C3, 1, 1, 1);
    step(0, '0, 1, 1, 1);

    ae_ofs = PW'(1); af_ofs = PW'(DEPTH - 1);
    do_reset(0);
    tag = "R2 load mode write";
    for (int i = 0; i < 3; i++) step(1, DW'(9'h040 + i), 0, 0, 1);
    tag = "R4 load mode ld low read";
    step(0, '0, 1, 1, 0);
    step(1, 9'h077, 0, 0, 0);
    tag = "R2 load mode read";
    for (int i = 0; i < 4; i++) step(0, '0, 1, 1, 1);

    @(negedge clk);
    mon_on = 0;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #1_000_000;
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule